// File: doc/BRIEF.md
# Transmit Character Guard with Shared Status Line

This block sits directly in front of a transmit line encoder. On each character clock it takes one 8-bit data byte, a 2-bit control code and a parity bit, and passes the character on after one register stage. When parity checking is on, a character with bad parity is not forwarded. A fixed bad-character code goes out in its place, so the far end of the link sees a code error where the corruption happened.

One status output per channel reports three conditions. The first is a one-character parity error pulse. The second is a pulse that marks the end of each built-in self-test pass, and its period and length depend on the clocking and encoder modes. The third is a latched phase-align buffer fault, which stays set until a full word-sync sequence has gone out or a transmit realignment is requested. A 2-bit source code beside the status output names the highest-priority condition that is active.

The clocking and bypass mode inputs are expected to stay constant while self-test is enabled.

Top module: `tx_char_guard`

## Requirements
- R1: Parity is odd over the 8 data bits, the 2 control bits and the parity bit. When `chk_en` is high at a clock edge and the character sampled there has an even count of ones, `status` is high for exactly the one cycle after that edge. When `chk_en` is low, parity has no effect.
- R2: After a parity failure, `out_data` is 8'hE0 and `out_ctl` is 2'b01 in the cycle after the edge. Every other character appears unchanged on `out_data`/`out_ctl` one cycle after it is sampled.
- R3: The substitution of R2 and the pulse of R1 behave the same whether `enc_bypass` is high or low.
- R4: With `bist_en` high and `common_clk` low, the self-test pass is 511 characters long. Counting the enabled edges from n=1, `status` is high for one cycle after each edge where n mod 511 = 510.
- R5: With `common_clk` high and `enc_bypass` low, the pass is 527 characters long (511 plus a 16-character word sync). `status` is high for 17 cycles, after the edges where n mod 527 lies in 510..526.
- R6: With `common_clk` high and `enc_bypass` high, no word sync is added. Pass length and pulse width follow R4.
- R7: When `buf_under` or `buf_over` is high at an edge, `status` is high from the next cycle. It stays high while neither `sync_done` nor `realign` is sampled high.
- R8: When `sync_done` or `realign` is sampled high and no fault strobe is high at that same edge, the latched fault is cleared from the next cycle. A fault strobe at the same edge keeps the flag set.
- R9: `status` is the OR of the three conditions. `status_src` is 3 for the latched fault, otherwise 2 for the self-test pulse, otherwise 1 for the parity pulse, otherwise 0.
- R10: When `rst` is sampled high, the next cycle shows `status`=0, `status_src`=0, `out_data`=0 and `out_ctl`=0, and the self-test count restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous reset, active high |
| chk_en | input | 1 | Parity checking enable |
| bist_en | input | 1 | Self-test progress enable |
| common_clk | input | 1 | Receive side uses a common clock (word sync added to passes) |
| enc_bypass | input | 1 | Encoder bypassed |
| in_data | input | 8 | Character data byte |
| in_ctl | input | 2 | Character control code |
| in_par | input | 1 | Parity bit of the character |
| sync_done | input | 1 | A complete word-sync sequence was sent |
| realign | input | 1 | Transmit realignment (reset) sampled active |
| buf_under | input | 1 | Phase-align buffer underflow strobe |
| buf_over | input | 1 | Phase-align buffer overflow strobe |
| out_data | output | 8 | Forwarded or substituted data byte |
| out_ctl | output | 2 | Forwarded or substituted control code |
| status | output | 1 | Shared status line |
| status_src | output | 2 | Highest-priority active status source |

## Verification
The hardest case to reach is the 17-cycle self-test pulse overlapping parity failures and a latched fault that is being set and cleared. The pulse only appears more than 500 characters into a pass, so short random runs never reach it. The stimulus therefore keeps self-test running for over two full 527-character passes in common-clock encoded mode. During that time it injects random bad-parity characters and occasional fault and clear strobes. A behavioural model tracks the pass position and fault flag and compares the priority code on every cycle.

// File: rtl/tx_char_guard.sv
module tx_char_guard #(
  parameter int DW = 8,
  parameter int CW = 2,
  parameter int PASS_LEN = 511,
  parameter int SYNC_LEN = 16,
  parameter logic [DW-1:0] BAD_DATA = 8'hE0,
  parameter logic [CW-1:0] BAD_CTL = 2'b01
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          chk_en,
  input  logic          bist_en,
  input  logic          common_clk,
  input  logic          enc_bypass,
  input  logic [DW-1:0] in_data,
  input  logic [CW-1:0] in_ctl,
  input  logic          in_par,
  input  logic          sync_done,
  input  logic          realign,
  input  logic          buf_under,
  input  logic          buf_over,
  output logic [DW-1:0] out_data,
  output logic [CW-1:0] out_ctl,
  output logic          status,
  output logic [1:0]    status_src
);
  localparam int PLONG = PASS_LEN + SYNC_LEN;
  localparam int CNTW = $clog2(PLONG + 1);
  localparam logic [CNTW-1:0] P_SHORT = CNTW'(PASS_LEN);
  localparam logic [CNTW-1:0] P_LONG = CNTW'(PLONG);
  localparam logic [CNTW-1:0] W_LONG = CNTW'(SYNC_LEN + 1);

  logic            par_q, fault_q, bist_act;
  logic [CNTW-1:0] cnt;

  wire par_fail = chk_en && !(^{in_data, in_ctl, in_par});
  wire wsync    = common_clk && !enc_bypass;
  wire [CNTW-1:0] period = wsync ? P_LONG : P_SHORT;
  wire [CNTW-1:0] start  = wsync ? (P_LONG - W_LONG) : (P_SHORT - 1'b1);
  wire bist_pulse = bist_act && (cnt >= start);
  wire fault_in   = buf_under || buf_over;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_data <= '0;
      out_ctl  <= '0;
      par_q    <= 1'b0;
    end else begin
      out_data <= par_fail ? BAD_DATA : in_data;
      out_ctl  <= par_fail ? BAD_CTL : in_ctl;
      par_q    <= par_fail;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                       fault_q <= 1'b0;
    else if (fault_in)             fault_q <= 1'b1;
    else if (sync_done || realign) fault_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || !bist_en) cnt <= '0;
    else if (cnt >= period - 1'b1) cnt <= '0;
    else cnt <= cnt + 1'b1;
    bist_act <= !rst && bist_en;
  end

  assign status     = fault_q || bist_pulse || par_q;
  assign status_src = fault_q ? 2'd3 : bist_pulse ? 2'd2 : par_q ? 2'd1 : 2'd0;

  p_sub_code_r2: assert property (@(posedge clk) disable iff (rst)
    par_q |-> (out_data == BAD_DATA && out_ctl == BAD_CTL));
  p_par_gate_r1: assert property (@(posedge clk) disable iff (rst)
    par_q |-> $past(chk_en));
  p_fault_set_r7: assert property (@(posedge clk) disable iff (rst)
    fault_in |=> status && status_src == 2'd3);
  p_fault_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (status_src == 2'd3 && !sync_done && !realign) |=> status_src == 2'd3);
  p_fault_clr_r8: assert property (@(posedge clk) disable iff (rst)
    ((sync_done || realign) && !fault_in) |=> status_src != 2'd3);
  p_cnt_range_r4: assert property (@(posedge clk) disable iff (rst)
    cnt < P_LONG);
  p_src_or_r9: assert property (@(posedge clk) disable iff (rst)
    status == (status_src != 2'd0));
endmodule

// File: tb/tb_tx_char_guard.sv
module tb_tx_char_guard;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1, chk_en = 1'b0, bist_en = 1'b0, common_clk = 1'b0, enc_bypass = 1'b0;
  logic [7:0] in_data = '0;
  logic [1:0] in_ctl = '0;
  logic in_par = 1'b0, sync_done = 1'b0, realign = 1'b0, buf_under = 1'b0, buf_over = 1'b0;
  logic [7:0] out_data;
  logic [1:0] out_ctl, status_src;
  logic status;

  tx_char_guard dut (.*);

  int total = 0, fails = 0;
  logic [7:0] m_data = '0;
  logic [1:0] m_ctl = '0;
  logic m_par = 0, m_fault = 0, m_act = 0;
  int m_n = 0;

  function automatic int per_now();
    return (common_clk && !enc_bypass) ? 527 : 511;
  endfunction

  always @(posedge clk) begin
    logic fail;
    fail = chk_en && ((^{in_data, in_ctl, in_par}) == 1'b0);
    if (rst) begin
      m_data = '0; m_ctl = '0; m_par = 0; m_fault = 0; m_act = 0; m_n = 0;
    end else begin
      m_data = fail ? 8'hE0 : in_data;
      m_ctl  = fail ? 2'b01 : in_ctl;
      m_par  = fail;
      if (buf_under || buf_over) m_fault = 1;
      else if (sync_done || realign) m_fault = 0;
      m_act = bist_en;
      m_n = bist_en ? (m_n + 1) % per_now() : 0;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(string rs, string rd);
    int wid, src;
    logic bp;
    @(negedge clk);
    wid = (common_clk && !enc_bypass) ? 17 : 1;
    bp = m_act && (m_n >= per_now() - wid);
    src = m_fault ? 3 : bp ? 2 : m_par ? 1 : 0;
    chk(rd, "out_data", out_data, m_data);
    chk(rd, "out_ctl", out_ctl, m_ctl);
    chk(rs, "status", status, src != 0);
    chk(rs, "status_src", status_src, src);
  endtask

  task automatic rnd_char();
    in_data = 8'($urandom); in_ctl = 2'($urandom); in_par = 1'($urandom);
  endtask

  task automatic good_char();
    rnd_char();
    in_par = ~(^{in_data, in_ctl});
  endtask

  task automatic bist_run(string req, int exp_hi);
    int hi = 0;
    bist_en = 1;
    for (int i = 0; i < 1100; i++) begin
      good_char();
      step(req, req);
      if (status) hi++;
    end
    chk(req, "pass pulse cycles", hi, exp_hi);
    bist_en = 0;
    step(req, req);
  endtask

  initial begin
    #1000000;
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    // R10: reset state
    step("R10", "R10"); step("R10", "R10");
    chk("R10", "status after reset", status, 0);
    rst = 0;
    // R1 / R2: random characters with checking on
    chk_en = 1;
    for (int i = 0; i < 200; i++) begin rnd_char(); step("R1", "R2"); end
    // R1: checking off, parity ignored
    chk_en = 0;
    for (int i = 0; i < 100; i++) begin rnd_char(); step("R1", "R2"); end
    // R3: bypass mode
    chk_en = 1; enc_bypass = 1;
    for (int i = 0; i < 100; i++) begin rnd_char(); step("R3", "R3"); end
    chk_en = 0; enc_bypass = 0;
    // R4 / R5 / R6: self-test pass pulses
    common_clk = 0; enc_bypass = 0; bist_run("R4", 2);
    common_clk = 1; enc_bypass = 0; bist_run("R5", 34);
    common_clk = 1; enc_bypass = 1; bist_run("R6", 2);
    common_clk = 0; enc_bypass = 0;
    // R7: fault set and held
    good_char();
    buf_under = 1; step("R7", "R7"); buf_under = 0;
    for (int i = 0; i < 20; i++) step("R7", "R7");
    chk("R7", "fault held", status_src, 3);
    // R8: cleared by sync_done, by realign, and fault wins a tie
    sync_done = 1; step("R8", "R8"); sync_done = 0; step("R8", "R8");
    chk("R8", "cleared by sync", status, 0);
    buf_over = 1; step("R8", "R8"); buf_over = 0;
    realign = 1; step("R8", "R8"); realign = 0; step("R8", "R8");
    chk("R8", "cleared by realign", status, 0);
    buf_over = 1; sync_done = 1; step("R8", "R8"); buf_over = 0; sync_done = 0;
    step("R8", "R8");
    chk("R8", "fault wins tie", status_src, 3);
    realign = 1; step("R8", "R8"); realign = 0;
    // R9: everything overlapping
    common_clk = 1; chk_en = 1; bist_en = 1;
    for (int i = 0; i < 1200; i++) begin
      int r;
      rnd_char();
      r = int'($urandom % 100);
      buf_under = (r == 0); buf_over = (r == 1);
      sync_done = (r >= 2 && r < 6); realign = (r == 6);
      step("R9", "R9");
    end
    buf_under = 0; buf_over = 0; sync_done = 0; realign = 0;
    // R10: mid-run reset clears fault and count
    buf_over = 1; step("R9", "R9"); buf_over = 0;
    rst = 1; step("R10", "R10"); rst = 0;
    chk("R10", "status after mid reset", status, 0);
    for (int i = 0; i < 600; i++) begin good_char(); step("R10", "R10"); end
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule